// File: doc/BRIEF.md
# Latched Event Status with Masked Interrupts

This block keeps three byte-wide event status registers whose bits capture hardware event pulses and hold them until the host clears them. It also shows a live, unlatched status byte and holds two interrupt enable bytes. Each of the first two status registers drives its own active-low interrupt line. The third status register raises no interrupt. Event inputs are sampled on every clock. A bit that is high in any cycle sets the matching latch bit, and that bit stays set.

To poll a status register, the host writes a select byte to that register's address. In the same edge, every bit where the select byte is 1 copies its latch value into a per-register read-back copy and clears the latch. Bits where the select byte is 0 keep both their read-back value and their latch. A read of the address then returns the read-back copy, so the host can sample chosen bits without disturbing the rest. The bus is synchronous: a write takes effect at the clock edge where `bus_wr` is high, and a read is combinational from `bus_addr`.

Top module: `evt_status_regs`

## Requirements
- R1: After reset, all latches, read-back copies and enable bytes are zero, every readable address returns 0 (except address 3, which shows `live_stat`), and both interrupt outputs are high.
- R2: A 1 on an event input bit in a cycle makes the matching latch bit 1 from the next clock edge. The bit stays 1 until a clear selects it.
- R3: A write to status address 0, 1 or 2 with select bit 1 loads that bit of the read-back copy with the latch value held before the edge and clears the latch bit. A read of the address then returns the copy.
- R4: For select bits of 0, the same write leaves both the read-back bit and the latch bit unchanged.
- R5: An event that is still present after a clear sets its bit again, so the next selecting write reads it as 1.
- R6: An event in the same cycle as a clearing write wins: the latch bit stays 1. The read-back copy from that write shows the value held before the edge.
- R7: Address 3 returns the `live_stat` input directly, with no latching and no need for a prior write. Writes to address 3 have no effect.
- R8: `irq1_n` is 0 exactly while some bit of status register 0 (address 0) and of enable byte 1 (address 4) are both 1. `irq2_n` behaves the same for status register 1 (address 1) and enable byte 2 (address 5). Status register 2 (address 2) drives no interrupt.
- R9: Enable bytes at addresses 4 and 5 read back the last value written to them.
- R10: Addresses 6 and 7 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data: select byte or enable byte |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| evt_st1 | input | 8 | Event inputs of status register 0 |
| evt_st2 | input | 8 | Event inputs of status register 1 |
| evt_info | input | 8 | Event inputs of status register 2 |
| live_stat | input | 8 | Real-time status shown at address 3 |
| irq1_n | output | 1 | Active-low interrupt for status register 0 |
| irq2_n | output | 1 | Active-low interrupt for status register 1 |

## Verification
The bench targets four corner cases.

- **Partial select.** The bench checks that deselected bits keep their old read-back value and stay latched. A design that cleared the whole register would lose pending events.
- **Event during a clearing write.** The bench raises an event in the same cycle as a clearing write. A design that gave the clear priority would drop that event.
- **Persistent condition.** The bench keeps an event high across clears to confirm the bit sets again.
- **Interrupt gating.** The bench checks that interrupts follow only enabled bits and ignore the third register. A wrong enable path would either raise spurious interrupts or hide real ones.

// File: rtl/evt_status_regs.sv
module evt_status_regs #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  evt_st1,
  input  logic [W-1:0]  evt_st2,
  input  logic [W-1:0]  evt_info,
  input  logic [W-1:0]  live_stat,
  output logic          irq1_n,
  output logic          irq2_n
);
  localparam int NLAT = 3;
  localparam logic [AW-1:0] A_LIVE = AW'(3);
  localparam logic [AW-1:0] A_EN1  = AW'(4);
  localparam logic [AW-1:0] A_EN2  = AW'(5);

  logic [W-1:0] evt_v [NLAT];
  logic [W-1:0] lat   [NLAT];
  logic [W-1:0] hld   [NLAT];
  logic [W-1:0] en1, en2;

  assign evt_v[0] = evt_st1;
  assign evt_v[1] = evt_st2;
  assign evt_v[2] = evt_info;

  for (genvar k = 0; k < NLAT; k++) begin : g_lat
    logic sel_wr;
    assign sel_wr = bus_wr && (bus_addr == AW'(k));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lat[k] <= '0;
        hld[k] <= '0;
      end else if (sel_wr) begin
        hld[k] <= (hld[k] & ~bus_wdata) | (lat[k] & bus_wdata);
        lat[k] <= (lat[k] & ~bus_wdata) | evt_v[k];
      end else begin
        lat[k] <= lat[k] | evt_v[k];
      end
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((lat[k] & $past(evt_v[k])) == $past(evt_v[k])));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> ((lat[k] & $past(bus_wdata) & ~$past(evt_v[k])) == '0));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> ((hld[k] & ~$past(bus_wdata)) == ($past(hld[k]) & ~$past(bus_wdata))));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en1 <= '0;
      en2 <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_EN1) en1 <= bus_wdata;
      if (bus_addr == A_EN2) en2 <= bus_wdata;
    end
  end

  assign irq1_n = ~|(lat[0] & en1);
  assign irq2_n = ~|(lat[1] & en2);

  always_comb begin
    case (bus_addr)
      AW'(0):  bus_rdata = hld[0];
      AW'(1):  bus_rdata = hld[1];
      AW'(2):  bus_rdata = hld[2];
      A_LIVE:  bus_rdata = live_stat;
      A_EN1:   bus_rdata = en1;
      A_EN2:   bus_rdata = en2;
      default: bus_rdata = '0;
    endcase
  end

  assert_irq1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(evt_st1 & en1)) && !(bus_wr && bus_addr == A_EN1)) |=> !irq1_n);

  assert_irq2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(evt_st2 & en2)) && !(bus_wr && bus_addr == A_EN2)) |=> !irq2_n);
endmodule

// File: tb/evt_status_regs_tb.sv
module evt_status_regs_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] evt_st1 = '0, evt_st2 = '0, evt_info = '0, live_stat = '0;
  logic       irq1_n, irq2_n;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_status_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_st1(evt_st1),
    .evt_st2(evt_st2), .evt_info(evt_info), .live_stat(live_stat),
    .irq1_n(irq1_n), .irq2_n(irq2_n));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic poll(input logic [2:0] a, input logic [7:0] m, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    wr(a, m);
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic pulse(input int k, input logic [7:0] v);
    @(negedge clk);
    if (k == 0) evt_st1 = v; else if (k == 1) evt_st2 = v; else evt_info = v;
    @(negedge clk);
    evt_st1 = '0; evt_st2 = '0; evt_info = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      if (a == 3) continue;
      rd(3'(a), d);
      chk("R1 reset read", d, 8'h00);
    end
    chk("R1 irq1_n", {7'd0, irq1_n}, 8'h01);
    chk("R1 irq2_n", {7'd0, irq2_n}, 8'h01);
  endtask

  task automatic t_latch;
    pulse(0, 8'h05);
    repeat (3) @(negedge clk);
    poll(0, 8'hFF, 8'h05, "R2 latched pulse");
    poll(0, 8'hFF, 8'h00, "R3 cleared after select");
  endtask

  task automatic t_partial;
    pulse(0, 8'hF0);
    poll(0, 8'h30, 8'h30, "R3 partial select");
    poll(0, 8'hC0, 8'hF0, "R4 deselected bits kept");
    poll(0, 8'hFF, 8'h00, "R4 all cleared");
  endtask

  task automatic t_persist;
    @(negedge clk); evt_info = 8'h01;
    poll(2, 8'hFF, 8'h01, "R5 first read");
    poll(2, 8'hFF, 8'h01, "R5 re-set while present");
    evt_info = 8'h00;
    poll(2, 8'hFF, 8'h01, "R5 last set");
    poll(2, 8'hFF, 8'h00, "R5 gone");
  endtask

  task automatic t_collide;
    logic [7:0] d;
    @(negedge clk);
    bus_addr = 3'd1; bus_wr = 1; bus_wdata = 8'hFF; evt_st2 = 8'h02;
    @(negedge clk);
    bus_wr = 0; evt_st2 = 8'h00;
    rd(1, d);
    chk("R6 read-back before edge", d, 8'h00);
    poll(1, 8'hFF, 8'h02, "R6 event survives clear");
  endtask

  task automatic t_live;
    logic [7:0] d;
    live_stat = 8'hA5;
    rd(3, d); chk("R7 live read", d, 8'hA5);
    wr(3, 8'h00);
    rd(3, d); chk("R7 write ignored", d, 8'hA5);
    live_stat = 8'h3C;
    rd(3, d); chk("R7 follows input", d, 8'h3C);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    wr(4, 8'h04);
    rd(4, d); chk("R9 enable1 readback", d, 8'h04);
    pulse(0, 8'h01);
    chk("R8 masked bit no irq", {7'd0, irq1_n}, 8'h01);
    pulse(0, 8'h04);
    chk("R8 irq1 asserted", {7'd0, irq1_n}, 8'h00);
    chk("R8 irq2 idle", {7'd0, irq2_n}, 8'h01);
    wr(0, 8'h04);
    chk("R8 irq1 released", {7'd0, irq1_n}, 8'h01);
    poll(0, 8'hFF, 8'h01, "R4 masked bit still latched");
    wr(5, 8'hFF);
    rd(5, d); chk("R9 enable2 readback", d, 8'hFF);
    pulse(2, 8'hFF);
    chk("R8 info reg no irq", {7'd0, irq2_n}, 8'h01);
    pulse(1, 8'h80);
    chk("R8 irq2 asserted", {7'd0, irq2_n}, 8'h00);
    wr(1, 8'hFF);
    chk("R8 irq2 released", {7'd0, irq2_n}, 8'h01);
    poll(2, 8'hFF, 8'hFF, "R2 info latched");
  endtask

  task automatic t_unused;
    logic [7:0] d;
    wr(6, 8'hFF); wr(7, 8'hFF);
    rd(6, d); chk("R10 addr6", d, 8'h00);
    rd(7, d); chk("R10 addr7", d, 8'h00);
    rd(4, d); chk("R10 enable1 intact", d, 8'h04);
    rd(5, d); chk("R10 enable2 intact", d, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_partial();
    t_persist();
    t_collide();
    t_live();
    t_irq();
    t_unused();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule